// File: doc/BRIEF.md
# Addressable Scan-Port Connect Controller

This block decides whether one drop of a multidrop scan link is connected to its local secondary test chains. An upstream decoder delivers each link-select frame already parsed: a one-cycle valid strobe, a 10-bit address and a 3-bit position. The block compares the frame with its strap inputs, which give the drop's own address and position. It also compares the address with three reserved global codes. From the result it sets a 2-bit link status of OFF, ON, RESET or MULTICAST.

A frame that selects this drop is answered first. The block raises an acknowledge output for a fixed number of test clocks, and the link turns ON only when the acknowledge is complete. Any other frame takes effect on the next test clock edge. In that case no acknowledge is sent.

The status drives the port gating. The secondary chains are linked in a daisy chain from the primary TDI to the primary TDO. The output enables to the pad cells open and close with the status. When a chain is deselected, its secondary TMS lines are frozen so that its TAP state is kept. Frames that arrive while the primary TAP is in Update-IR are ignored, and so are frames that arrive during an acknowledge.

Top module: `scan_link_connect`

## Requirements
- R1: A frame with address 0x000 sets status to RESET (code 2'b10) on the next rising tck, with no acknowledge; in RESET all stms lines are 1 and every output enable is 0.
- R2: A frame with address 0x3FF sets status to MULTICAST (code 2'b11) on the next rising tck, with no acknowledge; in MULTICAST every stms line equals ptms, every stdo equals ptdi with all stdo_oe bits 1, and ptdo_oe is 0.
- R3: A frame with address 0x3FE sets status to OFF (code 2'b00) on the next rising tck and raises no acknowledge.
- R4: A frame whose address equals strap_addr and whose position equals strap_pos (address not reserved) raises ack for exactly 8 tck cycles starting after the accepting edge; status keeps its old value during those cycles and becomes ON (code 2'b01) on the edge that ends the eighth cycle.
- R5: A frame with a non-reserved address where either the address or the position differs from the straps sets status to OFF on the next rising tck and raises no acknowledge.
- R6: In OFF, ptdo_oe and all stdo_oe bits are 0 and stms holds the level it had on the last edge before leaving ON, MULTICAST or RESET.
- R7: In ON, stdo[0]=ptdi, stdo[i]=sret[i-1], ptdo=sret[2], all output enables are 1 and every stms line equals ptms.
- R8: A frame that arrives while tap_state equals 4'hD (Update-IR) is ignored.
- R9: trst_n low asynchronously forces status OFF, ack 0, all output enables 0 and stms to all 1.
- R10: A frame that arrives while ack is high is dropped, and the acknowledge in progress completes to ON.
- R11: The reserved addresses act as in R1, R2 and R3 even when the straps equal them; no acknowledge is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| frm_valid | input | 1 | Decoded frame strobe, one cycle |
| frm_addr | input | 10 | Frame address |
| frm_pos | input | 3 | Frame position |
| strap_addr | input | 10 | Local address straps |
| strap_pos | input | 3 | Local position straps |
| tap_state | input | 4 | Primary TAP state (4'hD = Update-IR) |
| ptms | input | 1 | Primary TMS |
| ptdi | input | 1 | Primary TDI |
| sret | input | 3 | Return data from each secondary chain |
| stms | output | 3 | Secondary TMS lines |
| stdo | output | 3 | Secondary TDO data |
| stdo_oe | output | 3 | Secondary TDO pad enables |
| ptdo | output | 1 | Primary TDO data |
| ptdo_oe | output | 1 | Primary TDO pad enable |
| ack | output | 1 | Acknowledge sequence in progress |
| status | output | 2 | Link status: 00 OFF, 01 ON, 10 RESET, 11 MULTICAST |

## Verification
The assertions check on every cycle that each accepted frame class moves the status as its requirement says. They also check that ack only ever falls into ON, that Update-IR and busy frames leave the status alone, and that OFF keeps the pads disabled with TMS frozen at the value captured on the disconnecting edge. Only the bench scenarios can show the exact eight-cycle acknowledge length, that reserved codes win over equal straps, and the daisy-chain data routing against varying ptms, ptdi and sret. The same holds for recovery from a reset in mid-connection. A behavioural reference model compares every output on every clock.

// File: rtl/scl_pkg.sv
package scl_pkg;

  typedef enum logic [1:0] {
    ST_OFF   = 2'b00,
    ST_ON    = 2'b01,
    ST_RESET = 2'b10,
    ST_MCAST = 2'b11
  } link_st_e;

  typedef enum logic [2:0] {
    FR_RESET,
    FR_SYNC,
    FR_DISC,
    FR_MATCH,
    FR_MISS
  } frame_cls_e;

  // Status an accepted frame leads to; FR_MATCH defers, so the old status stays.
  function automatic link_st_e status_after(input frame_cls_e cls, input link_st_e cur);
    case (cls)
      FR_RESET: return ST_RESET;
      FR_SYNC:  return ST_MCAST;
      FR_MATCH: return cur;
      default:  return ST_OFF;
    endcase
  endfunction

endpackage

// File: rtl/scl_frame_decode.sv
module scl_frame_decode
  import scl_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int POS_W  = 3
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [POS_W-1:0]  pos,
  input  logic [ADDR_W-1:0] strap_addr,
  input  logic [POS_W-1:0]  strap_pos,
  output frame_cls_e        cls
);
  localparam logic [ADDR_W-1:0] RST_CODE  = '0;
  localparam logic [ADDR_W-1:0] SYNC_CODE = '1;
  localparam logic [ADDR_W-1:0] DISC_CODE = {{(ADDR_W-1){1'b1}}, 1'b0};

  // Reserved codes are tested first so that they win over equal straps.
  always_comb begin
    if (addr == RST_CODE)                              cls = FR_RESET;
    else if (addr == SYNC_CODE)                        cls = FR_SYNC;
    else if (addr == DISC_CODE)                        cls = FR_DISC;
    else if (addr == strap_addr && pos == strap_pos)   cls = FR_MATCH;
    else                                               cls = FR_MISS;
  end
endmodule

// File: rtl/scl_ack_timer.sv
module scl_ack_timer #(
  parameter int ACK_LEN = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int CW = $clog2(ACK_LEN + 1);
  localparam logic [CW-1:0] LOAD = CW'(ACK_LEN);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (start)   cnt <= LOAD;
    else if (busy)    cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);
  assign done = (cnt == CW'(1));

  // R4: an acknowledge only begins because a start was requested
  assert_ack_begins_on_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));
  // R10: the caller never restarts a running acknowledge
  assert_no_restart_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !start);
endmodule

// File: rtl/scl_link_state.sv
module scl_link_state
  import scl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       accept,
  input  frame_cls_e cls,
  input  logic       ack_done,
  output link_st_e   status,
  output logic       ack_start
);
  assign ack_start = accept && (cls == FR_MATCH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        status <= ST_OFF;
    else if (accept)   status <= status_after(cls, status);
    else if (ack_done) status <= ST_ON;
  end

  assert_reset_code_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cls == FR_RESET) |=> status == ST_RESET);
  assert_sync_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cls == FR_SYNC) |=> status == ST_MCAST);
  assert_disc_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cls == FR_DISC) |=> status == ST_OFF);
  assert_miss_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cls == FR_MISS) |=> status == ST_OFF);
  assert_match_defers_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cls == FR_MATCH) |=> $stable(status));
endmodule

// File: rtl/scl_port_gate.sv
module scl_port_gate
  import scl_pkg::*;
#(
  parameter int NSEC = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  link_st_e        status,
  input  logic            ptms,
  input  logic            ptdi,
  input  logic [NSEC-1:0] sret,
  output logic [NSEC-1:0] stms,
  output logic [NSEC-1:0] stdo,
  output logic [NSEC-1:0] stdo_oe,
  output logic            ptdo,
  output logic            ptdo_oe
);
  logic            follow;
  logic [NSEC-1:0] hold;
  logic [NSEC-1:0] chain_in;

  assign follow = (status == ST_ON) || (status == ST_MCAST);

  // Last driven TMS level, frozen while OFF.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   hold <= '1;
    else if (follow)              hold <= {NSEC{ptms}};
    else if (status == ST_RESET)  hold <= '1;
  end

  generate
    for (genvar i = 0; i < NSEC; i++) begin : g_link
      if (i == 0) begin : g_head
        assign chain_in[i] = ptdi;
      end else begin : g_body
        assign chain_in[i] = sret[i-1];
      end
      assign stdo[i] = (status == ST_MCAST) ? ptdi : chain_in[i];
    end
  endgenerate

  always_comb begin
    if (status == ST_RESET) stms = '1;
    else if (follow)        stms = {NSEC{ptms}};
    else                    stms = hold;
  end

  assign stdo_oe = follow ? '1 : '0;
  assign ptdo    = sret[NSEC-1];
  assign ptdo_oe = (status == ST_ON);

  assert_off_pads_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (status == ST_OFF) |-> (stdo_oe == '0 && !ptdo_oe));
  assert_off_tms_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (status == ST_OFF && $past(status) == ST_OFF) |-> $stable(stms));
  assert_freeze_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(status) == ST_ON && status == ST_OFF) |-> stms == {NSEC{$past(ptms)}});
  assert_on_pads_open_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (status == ST_ON) |-> (ptdo_oe && stdo_oe == '1));
endmodule

// File: rtl/scan_link_connect.sv
module scan_link_connect
  import scl_pkg::*;
#(
  parameter int              ADDR_W   = 10,
  parameter int              POS_W    = 3,
  parameter int              NSEC     = 3,
  parameter int              ACK_LEN  = 8,
  parameter int              TAPST_W  = 4,
  parameter logic [TAPST_W-1:0] UPD_IR_STATE = 4'hD
) (
  input  logic               tck,
  input  logic               trst_n,
  input  logic               frm_valid,
  input  logic [ADDR_W-1:0]  frm_addr,
  input  logic [POS_W-1:0]   frm_pos,
  input  logic [ADDR_W-1:0]  strap_addr,
  input  logic [POS_W-1:0]   strap_pos,
  input  logic [TAPST_W-1:0] tap_state,
  input  logic               ptms,
  input  logic               ptdi,
  input  logic [NSEC-1:0]    sret,
  output logic [NSEC-1:0]    stms,
  output logic [NSEC-1:0]    stdo,
  output logic [NSEC-1:0]    stdo_oe,
  output logic               ptdo,
  output logic               ptdo_oe,
  output logic               ack,
  output logic [1:0]         status
);
  localparam logic [ADDR_W-1:0] RSV_LOW  = '0;
  localparam logic [ADDR_W-1:0] RSV_HIGH = '1;
  localparam logic [ADDR_W-1:0] RSV_DISC = {{(ADDR_W-1){1'b1}}, 1'b0};

  frame_cls_e cls;
  link_st_e   st;
  logic       accept;
  logic       ack_start;
  logic       ack_busy;
  logic       ack_done;
  logic       in_upd_ir;

  assign in_upd_ir = (tap_state == UPD_IR_STATE);
  assign accept    = frm_valid && !in_upd_ir && !ack_busy;

  scl_frame_decode #(.ADDR_W(ADDR_W), .POS_W(POS_W)) u_decode (
    .addr(frm_addr), .pos(frm_pos),
    .strap_addr(strap_addr), .strap_pos(strap_pos),
    .cls(cls)
  );

  scl_ack_timer #(.ACK_LEN(ACK_LEN)) u_ack (
    .clk(tck), .rst_n(trst_n), .start(ack_start),
    .busy(ack_busy), .done(ack_done)
  );

  scl_link_state u_state (
    .clk(tck), .rst_n(trst_n), .accept(accept), .cls(cls),
    .ack_done(ack_done), .status(st), .ack_start(ack_start)
  );

  scl_port_gate #(.NSEC(NSEC)) u_gate (
    .clk(tck), .rst_n(trst_n), .status(st),
    .ptms(ptms), .ptdi(ptdi), .sret(sret),
    .stms(stms), .stdo(stdo), .stdo_oe(stdo_oe),
    .ptdo(ptdo), .ptdo_oe(ptdo_oe)
  );

  assign ack    = ack_busy;
  assign status = st;

  assert_ack_ends_on_R4: assert property (@(posedge tck) disable iff (!trst_n)
    $fell(ack) |-> status == 2'b01);
  assert_updir_ignored_R8: assert property (@(posedge tck) disable iff (!trst_n)
    (frm_valid && in_upd_ir && !ack) |=> ($stable(status) && !ack));
  assert_busy_frame_dropped_R10: assert property (@(posedge tck) disable iff (!trst_n)
    (frm_valid && ack) |=> ($stable(status) || status == 2'b01));
  assert_reserved_no_ack_R11: assert property (@(posedge tck) disable iff (!trst_n)
    (accept && (frm_addr == RSV_LOW || frm_addr == RSV_HIGH || frm_addr == RSV_DISC))
      |=> !ack);
endmodule

// File: tb/sim_scan_link_connect.sv
module sim_scan_link_connect;
  localparam int CLK_PERIOD = 10;

  logic       tck = 1'b0;
  logic       trst_n = 1'b0;
  logic       frm_valid = 1'b0;
  logic [9:0] frm_addr = '0;
  logic [2:0] frm_pos = '0;
  logic [9:0] strap_addr = 10'h155;
  logic [2:0] strap_pos = 3'd5;
  logic [3:0] tap_state = 4'h1;
  logic       ptms = 1'b0;
  logic       ptdi = 1'b0;
  logic [2:0] sret = '0;
  logic [2:0] stms, stdo, stdo_oe;
  logic       ptdo, ptdo_oe, ack;
  logic [1:0] status;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  scan_link_connect u0 (
    .tck(tck), .trst_n(trst_n), .frm_valid(frm_valid), .frm_addr(frm_addr),
    .frm_pos(frm_pos), .strap_addr(strap_addr), .strap_pos(strap_pos),
    .tap_state(tap_state), .ptms(ptms), .ptdi(ptdi), .sret(sret),
    .stms(stms), .stdo(stdo), .stdo_oe(stdo_oe), .ptdo(ptdo),
    .ptdo_oe(ptdo_oe), .ack(ack), .status(status)
  );

  always #(CLK_PERIOD/2) tck = ~tck;

  // Pseudo-random primary TMS/TDI and chain return data.
  int unsigned lfsr = 32'hACE1_2468;
  always @(negedge tck) begin
    lfsr = lfsr ^ (lfsr << 13);
    lfsr = lfsr ^ (lfsr >> 17);
    lfsr = lfsr ^ (lfsr << 5);
    ptms = lfsr[3];
    ptdi = lfsr[9];
    sret = lfsr[20:18];
  end

  // Reference model: status 0 OFF, 1 ON, 2 RESET, 3 MULTICAST.
  int       m_st = 0;
  int       m_left = 0;
  bit [2:0] m_hold = 3'b111;

  always @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      m_st = 0; m_left = 0; m_hold = 3'b111;
    end else begin
      bit take;
      take = frm_valid && (tap_state != 4'hD) && (m_left == 0);
      if (m_st == 1 || m_st == 3) m_hold = {3{ptms}};
      else if (m_st == 2)         m_hold = 3'b111;
      if (m_left > 0) begin
        m_left = m_left - 1;
        if (m_left == 0) m_st = 1;
      end
      if (take) begin
        if (frm_addr == 10'h000)      m_st = 2;
        else if (frm_addr == 10'h3FF) m_st = 3;
        else if (frm_addr == 10'h3FE) m_st = 0;
        else if (frm_addr == strap_addr && frm_pos == strap_pos) m_left = 8;
        else m_st = 0;
      end
    end
  end

  task automatic fail_line(input string req, input string what, input int act, input int exp);
    failures++;
    $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
  endtask

  // Full output comparison one time unit after every rising edge.
  always @(posedge tck) begin
    #1;
    if (trst_n && !finished) begin
      bit [2:0] e_stms, e_oe, e_stdo;
      bit       e_poe;
      bit       bad;
      bad = 0;
      e_oe  = (m_st == 1 || m_st == 3) ? 3'b111 : 3'b000;
      e_poe = (m_st == 1);
      if (m_st == 2)       e_stms = 3'b111;
      else if (e_oe != 0)  e_stms = {3{ptms}};
      else                 e_stms = m_hold;
      e_stdo = (m_st == 3) ? {3{ptdi}} : {sret[1], sret[0], ptdi};
      checks++;
      if (status != 2'(m_st)) begin fail_line("R4", "status", status, m_st); bad = 1; end
      if (ack != (m_left > 0)) begin fail_line("R4", "ack", ack, m_left > 0); bad = 1; end
      if (stdo_oe != e_oe || ptdo_oe != e_poe) begin
        fail_line("R6", "oe", {ptdo_oe, stdo_oe}, {e_poe, e_oe}); bad = 1;
      end
      if (stms != e_stms) begin fail_line("R6", "stms", stms, e_stms); bad = 1; end
      if (e_oe != 0 && stdo != e_stdo) begin fail_line("R7", "stdo", stdo, e_stdo); bad = 1; end
      if (e_poe && ptdo != sret[2]) begin fail_line("R7", "ptdo", ptdo, sret[2]); bad = 1; end
      if (bad) checks += 0;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) fail_line(req, "scenario", act, exp);
  endtask

  task automatic send(input logic [9:0] a, input logic [2:0] p);
    @(negedge tck);
    frm_valid = 1'b1; frm_addr = a; frm_pos = p;
    @(negedge tck);
    frm_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge tck);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    idle(3);
    // R9: reset state
    check(status == 2'b00 && !ack && stdo_oe == 0 && !ptdo_oe && stms == 3'b111,
          "R9", {status, ack, stms}, 6'b000111);
    @(negedge tck) trst_n = 1'b1;
    idle(2);

    // R4: match, ack eight cycles, then ON
    send(10'h155, 3'd5);
    check(ack && status == 2'b00, "R4", {ack, status}, 3'b100);
    for (int k = 1; k < 8; k++) begin
      @(negedge tck);
      check(ack && status == 2'b00, "R4", {ack, status}, 3'b100);
    end
    @(negedge tck);
    check(!ack && status == 2'b01, "R4", {ack, status}, 3'b001);
    // R7: ON pads open
    check(ptdo_oe && stdo_oe == 3'b111, "R7", {ptdo_oe, stdo_oe}, 4'hF);
    idle(4);

    // R5: position mismatch goes OFF at once
    send(10'h155, 3'd4);
    check(status == 2'b00 && !ack, "R5", {status, ack}, 0);
    check(stdo_oe == 0 && !ptdo_oe, "R6", {ptdo_oe, stdo_oe}, 0);
    idle(5);

    // R10: frame during ack is dropped
    send(10'h155, 3'd5);
    idle(2);
    send(10'h3FE, 3'd0);
    check(ack, "R10", ack, 1);
    idle(5);
    check(status == 2'b01 && !ack, "R10", status, 1);
    idle(3);

    // R5: address mismatch from ON
    send(10'h156, 3'd5);
    check(status == 2'b00 && !ack, "R5", status, 0);
    idle(3);

    // R3: disconnect code
    send(10'h155, 3'd5); idle(9);
    send(10'h3FE, 3'd5);
    check(status == 2'b00 && !ack, "R3", {status, ack}, 0);
    idle(3);

    // R1: reset code
    send(10'h000, 3'd2);
    check(status == 2'b10 && !ack && stms == 3'b111, "R1", {status, stms}, 5'b10111);
    idle(3);

    // R2: multicast code
    send(10'h3FF, 3'd1);
    check(status == 2'b11 && !ack && !ptdo_oe && stdo_oe == 3'b111, "R2",
          {status, ptdo_oe}, 3'b110);
    idle(3);

    // R8: frame during Update-IR ignored
    @(negedge tck) tap_state = 4'hD;
    send(10'h3FE, 3'd0);
    check(status == 2'b11, "R8", status, 3);
    send(10'h155, 3'd5);
    check(!ack && status == 2'b11, "R8", {ack, status}, 3);
    @(negedge tck) tap_state = 4'h1;
    idle(3);

    // R11: reserved codes win over equal straps
    @(negedge tck) begin strap_addr = 10'h3FE; strap_pos = 3'd2; end
    send(10'h3FE, 3'd2);
    check(status == 2'b00 && !ack, "R11", {status, ack}, 0);
    @(negedge tck) strap_addr = 10'h000;
    send(10'h000, 3'd2);
    check(status == 2'b10 && !ack, "R11", {status, ack}, 4);
    @(negedge tck) begin strap_addr = 10'h2A3; strap_pos = 3'd7; end
    idle(2);

    // R9: asynchronous reset while connected
    send(10'h2A3, 3'd7); idle(9);
    check(status == 2'b01, "R9", status, 1);
    #2 trst_n = 1'b0;
    #1 check(status == 2'b00 && !ack && stms == 3'b111 && stdo_oe == 0 && !ptdo_oe,
             "R9", {status, stms}, 5'b00111);
    idle(2);
    @(negedge tck) trst_n = 1'b1;
    idle(4);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule